// File: doc/BRIEF.md
# Real-Time Clock Register Bank

This block is the byte-wide register store that sits between a serial host interface and the time-keeping logic of a real-time clock. Sixteen 8-bit locations, selected by a 4-bit index, hold the BCD calendar and time counters, a frequency trim value, two alarm sets (minute, hour, weekday mask) and two control bytes. A host engine writes through a single-cycle write strobe, reads combinationally from the same index, and signals the end of each bus transaction with a stop strobe.

On top of plain storage the block implements the control semantics of the clock. Bit positions with no function are never stored and always read as zero. One bit of the second control byte behaves differently for writes and reads: a written 1 issues a one-cycle adjust request to the counter logic, a written 0 clears the oscillator-stop flag, and reads return that flag. Whenever the oscillator-stop flag is set, the trim value, the periodic-interrupt select field, both alarm enables and the interrupt-select bit are forced to zero. A factory test bit is cleared by the bus stop strobe, and each alarm raises a sticky flag when it is enabled and the current minute, hour and weekday match.

Top module: `rtc_regbank`

## Requirements
- R1: Unused bit positions are never stored and read 0. Writable masks by index: 0 7F, 1 7F, 2 3F, 3 07, 4 3F, 5 1F, 6 FF, 7 7F, 8 7F, 9 3F, A 7F, B 7F, C 3F, D 7F, E CF, F 3F.
- R2: Indices 0 to D store the written value under the mask of R1: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 trim, 8/9/A alarm A minute/hour/weekday mask, B/C/D alarm B minute/hour/weekday mask.
- R3: After reset every location reads 0 except index F, which reads 10h (oscillator-stop flag set).
- R4: A write to index F with bit 4 = 1 drives `adj_pulse` high for exactly the next cycle and leaves the oscillator-stop flag (F bit 4 on read) unchanged.
- R5: A write to index F with bit 4 = 0 clears the oscillator-stop flag, unless `osc_stop` is high in the same cycle.
- R6: `osc_stop` high sets the flag and zeroes index 7, index E bits 7, 6, 2:0 and index F bit 3 (interrupt select) on the next edge, overriding any write in that cycle.
- R7: `stop_strobe` clears index E bit 3 (test) on the next edge, overriding a write of 1 in that cycle.
- R8: Alarm A (enable E bit 7, flag F bit 1) and alarm B (enable E bit 6, flag F bit 0) set their flag one edge after enable is 1, minute equals the alarm minute, hour equals the alarm hour and the weekday mask bit at the weekday index (0 to 6) is 1; weekday 7 never matches.
- R9: An alarm flag is cleared only by writing 0 to it at index F; writing 1 keeps it, and a match in the same cycle as the clearing write keeps it set.
- R10: `rd_data` shows the location selected by `addr` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register index for reads and writes |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_data | input | 8 | Write data |
| stop_strobe | input | 1 | Bus stop condition seen, one cycle |
| osc_stop | input | 1 | Oscillator stop detected |
| rd_data | output | 8 | Read data for `addr` |
| adj_pulse | output | 1 | One-cycle adjust request to counter logic |

## Verification
The assertions assume the host drives `addr`, `wr_en` and `wr_data` steady across each clock edge and that `osc_stop` and `stop_strobe` are synchronous to `clk`; they are disabled until the internal reset release has completed. The stimulus changes inputs only on falling edges, issues no writes during or shortly after reset, and exercises the overlaps the rules rank (stop-flag set against a clearing write, stop strobe against a test-bit write, alarm match against a flag-clearing write) as single deliberate cycles.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;

  localparam int REG_ADDR_W = 4;
  localparam int REG_DATA_W = 8;
  localparam int REG_COUNT  = 1 << REG_ADDR_W;

  typedef enum logic [REG_ADDR_W-1:0] {
    IX_SEC   = 4'h0,
    IX_MIN   = 4'h1,
    IX_HOUR  = 4'h2,
    IX_WDAY  = 4'h3,
    IX_DAY   = 4'h4,
    IX_MON   = 4'h5,
    IX_YEAR  = 4'h6,
    IX_TRIM  = 4'h7,
    IX_AMIN  = 4'h8,
    IX_AHOUR = 4'h9,
    IX_AWDAY = 4'hA,
    IX_BMIN  = 4'hB,
    IX_BHOUR = 4'hC,
    IX_BWDAY = 4'hD,
    IX_CTL1  = 4'hE,
    IX_CTL2  = 4'hF
  } rtc_index_e;

  // control byte 1 bit positions
  localparam int C1_ENA  = 7;
  localparam int C1_ENB  = 6;
  localparam int C1_TEST = 3;
  // control byte 2 bit positions
  localparam int C2_MODE = 5;
  localparam int C2_STOP = 4;
  localparam int C2_ISEL = 3;
  localparam int C2_PFLG = 2;
  localparam int C2_FLGA = 1;
  localparam int C2_FLGB = 0;

  function automatic logic [REG_DATA_W-1:0] rtc_field_mask(input logic [REG_ADDR_W-1:0] ix);
    case (ix)
      IX_HOUR, IX_AHOUR, IX_BHOUR, IX_DAY: rtc_field_mask = 8'h3F;
      IX_WDAY:                             rtc_field_mask = 8'h07;
      IX_MON:                              rtc_field_mask = 8'h1F;
      IX_YEAR:                             rtc_field_mask = 8'hFF;
      IX_CTL1:                             rtc_field_mask = 8'hCF;
      IX_CTL2:                             rtc_field_mask = 8'h3F;
      default:                             rtc_field_mask = 8'h7F;
    endcase
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int DW   = 8,
  parameter int DAYS = 7
) (
  input  logic          enable,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hour,
  input  logic [DW-1:0] cur_wday,
  input  logic [DW-1:0] alm_min,
  input  logic [DW-1:0] alm_hour,
  input  logic [DW-1:0] alm_mask,
  output logic          hit
);
  localparam int WI = $clog2(DAYS + 1);

  logic [WI-1:0]   day_ix;
  logic [DAYS:0]   day_bits;
  logic            day_ok;

  always_comb begin
    day_ix   = cur_wday[WI-1:0];
    day_bits = {1'b0, alm_mask[DAYS-1:0]};
    day_ok   = (cur_wday < DW'(DAYS)) && day_bits[day_ix];
    hit      = enable && (cur_min == alm_min) && (cur_hour == alm_hour) && day_ok;
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ALARMS      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  wr_en,
  input  logic [REG_DATA_W-1:0] wr_data,
  input  logic                  stop_strobe,
  input  logic                  osc_stop,
  output logic [REG_DATA_W-1:0] rd_data,
  output logic                  adj_pulse
);
  localparam int PLAIN_N   = REG_COUNT - 2;
  localparam int ALM_BASE  = int'(IX_AMIN);
  localparam int ALM_SPAN  = 3;

  logic rst_n_s;

  rtc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  // plain storage for indices 0..D
  logic [REG_DATA_W-1:0] mem_q [PLAIN_N];
  logic [REG_DATA_W-1:0] mem_d [PLAIN_N];
  // control byte 1 (stored masked)
  logic [REG_DATA_W-1:0] ctl1_q, ctl1_d;
  // control byte 2 fields
  logic mode_q, mode_d;
  logic xstp_q, xstp_d;
  logic isel_q, isel_d;
  logic pflg_q, pflg_d;
  logic [ALARMS-1:0] flag_q, flag_d;
  logic adj_q, adj_d;
  logic [ALARMS-1:0] alarm_hit;

  logic wr_ctl1, wr_ctl2;
  assign wr_ctl1 = wr_en && (addr == IX_CTL1);
  assign wr_ctl2 = wr_en && (addr == IX_CTL2);

  // alarm comparators, one per alarm set
  for (genvar g = 0; g < ALARMS; g++) begin : g_alarm
    rtc_alarm_match #(.DW(REG_DATA_W), .DAYS(7)) u_match (
      .enable   (ctl1_q[C1_ENA - g]),
      .cur_min  (mem_q[IX_MIN]),
      .cur_hour (mem_q[IX_HOUR]),
      .cur_wday (mem_q[IX_WDAY]),
      .alm_min  (mem_q[ALM_BASE + ALM_SPAN*g]),
      .alm_hour (mem_q[ALM_BASE + ALM_SPAN*g + 1]),
      .alm_mask (mem_q[ALM_BASE + ALM_SPAN*g + 2]),
      .hit      (alarm_hit[g])
    );
  end

  // next state
  always_comb begin
    for (int i = 0; i < PLAIN_N; i++) begin
      mem_d[i] = mem_q[i];
      if (wr_en && (addr == i[REG_ADDR_W-1:0]))
        mem_d[i] = wr_data & rtc_field_mask(i[REG_ADDR_W-1:0]);
    end
    if (osc_stop) mem_d[IX_TRIM] = '0;

    ctl1_d = ctl1_q;
    if (wr_ctl1)     ctl1_d = wr_data & rtc_field_mask(IX_CTL1);
    if (stop_strobe) ctl1_d[C1_TEST] = 1'b0;
    if (osc_stop)    ctl1_d = ctl1_d & (REG_DATA_W'(1) << C1_TEST);

    mode_d = mode_q;
    xstp_d = xstp_q;
    isel_d = isel_q;
    pflg_d = pflg_q;
    flag_d = flag_q;
    adj_d  = wr_ctl2 && wr_data[C2_STOP];
    if (wr_ctl2) begin
      mode_d = wr_data[C2_MODE];
      if (!wr_data[C2_STOP]) xstp_d = 1'b0;
      isel_d = wr_data[C2_ISEL];
      pflg_d = wr_data[C2_PFLG];
      for (int g = 0; g < ALARMS; g++)
        flag_d[g] = flag_q[g] & wr_data[C2_FLGA - g];
    end
    if (osc_stop) begin
      xstp_d = 1'b1;
      isel_d = 1'b0;
    end
    flag_d = flag_d | alarm_hit;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int i = 0; i < PLAIN_N; i++) mem_q[i] <= '0;
      ctl1_q <= '0;
      mode_q <= 1'b0;
      xstp_q <= 1'b1;
      isel_q <= 1'b0;
      pflg_q <= 1'b0;
      flag_q <= '0;
      adj_q  <= 1'b0;
    end else begin
      for (int i = 0; i < PLAIN_N; i++) mem_q[i] <= mem_d[i];
      ctl1_q <= ctl1_d;
      mode_q <= mode_d;
      xstp_q <= xstp_d;
      isel_q <= isel_d;
      pflg_q <= pflg_d;
      flag_q <= flag_d;
      adj_q  <= adj_d;
    end
  end

  // read path
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < PLAIN_N; i++)
      if (addr == i[REG_ADDR_W-1:0]) rd_data = mem_q[i];
    if (addr == IX_CTL1) rd_data = ctl1_q;
    if (addr == IX_CTL2) begin
      rd_data[C2_MODE] = mode_q;
      rd_data[C2_STOP] = xstp_q;
      rd_data[C2_ISEL] = isel_q;
      rd_data[C2_PFLG] = pflg_q;
      for (int g = 0; g < ALARMS; g++) rd_data[C2_FLGA - g] = flag_q[g];
    end
  end

  assign adj_pulse = adj_q;

endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
  import rtc_regbank_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n_s,
  input logic [REG_ADDR_W-1:0] addr,
  input logic                  wr_en,
  input logic [REG_DATA_W-1:0] wr_data,
  input logic                  stop_strobe,
  input logic                  osc_stop,
  input logic [REG_DATA_W-1:0] rd_data,
  input logic                  adj_pulse,
  input logic                  xstp_q,
  input logic                  isel_q,
  input logic [REG_DATA_W-1:0] ctl1_q,
  input logic [REG_DATA_W-1:0] trim_q,
  input logic [1:0]            flag_q,
  input logic [1:0]            alarm_hit
);
  p_unused_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_data & ~rtc_field_mask(addr)) == '0);

  p_adj_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    adj_pulse |-> $past(wr_en && addr == IX_CTL2 && wr_data[C2_STOP]));

  p_stop_flag_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && addr == IX_CTL2 && !wr_data[C2_STOP] && !osc_stop) |=> !xstp_q);

  p_osc_stop_resets_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    osc_stop |=> (xstp_q && !isel_q && trim_q == '0 && ctl1_q[7:6] == 2'b00 && ctl1_q[2:0] == 3'b000));

  p_test_bit_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    stop_strobe |=> !ctl1_q[C1_TEST]);

  p_flag_a_source_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flag_q[0]) |-> $past(alarm_hit[0]));

  p_flag_b_source_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flag_q[1]) |-> $past(alarm_hit[1]));

  p_flag_a_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flag_q[0] && !(wr_en && addr == IX_CTL2 && !wr_data[C2_FLGA])) |=> flag_q[0]);
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .addr        (addr),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .stop_strobe (stop_strobe),
  .osc_stop    (osc_stop),
  .rd_data     (rd_data),
  .adj_pulse   (adj_pulse),
  .xstp_q      (xstp_q),
  .isel_q      (isel_q),
  .ctl1_q      (ctl1_q),
  .trim_q      (mem_q[7]),
  .flag_q      (flag_q),
  .alarm_hit   (alarm_hit)
);

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       stop_strobe;
  logic       osc_stop;
  logic [7:0] rd_data;
  logic       adj_pulse;

  int    total = 0;
  int    bad   = 0;
  int    cycles = 0;
  bit    live  = 1'b0;
  string tag   = "R3";

  // behavioural reference state
  logic [7:0] m [16];
  logic       madj;

  always #10 clk = ~clk;

  rtc_regbank uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .stop_strobe (stop_strobe),
    .osc_stop    (osc_stop),
    .rd_data     (rd_data),
    .adj_pulse   (adj_pulse)
  );

  function automatic logic [7:0] spec_mask(input int a);
    case (a)
      2, 4, 9, 12: return 8'h3F;
      3:           return 8'h07;
      5:           return 8'h1F;
      6:           return 8'hFF;
      14:          return 8'hCF;
      15:          return 8'h3F;
      default:     return 8'h7F;
    endcase
  endfunction

  function automatic bit alarm_match(input int base, input int en_bit);
    int wd;
    wd = int'(m[3]);
    return m[14][en_bit] && (m[1] == m[base]) && (m[2] == m[base+1]) &&
           (wd < 7) && m[base+2][wd];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) m[k] = 8'h00;
      m[15] = 8'h10;
      madj  = 1'b0;
    end else begin
      bit ha, hb;
      ha = alarm_match(8, 7);
      hb = alarm_match(11, 6);
      madj = wr_en && addr == 4'hF && wr_data[4];
      if (wr_en) begin
        if (addr < 4'hF) m[addr] = wr_data & spec_mask(int'(addr));
        else begin
          m[15][5] = wr_data[5];
          if (!wr_data[4]) m[15][4] = 1'b0;
          m[15][3] = wr_data[3];
          m[15][2] = wr_data[2];
          m[15][1] = m[15][1] & wr_data[1];
          m[15][0] = m[15][0] & wr_data[0];
        end
      end
      if (stop_strobe) m[14][3] = 1'b0;
      if (osc_stop) begin
        m[15][4] = 1'b1;
        m[15][3] = 1'b0;
        m[7]     = 8'h00;
        m[14]    = m[14] & 8'h08;
      end
      if (ha) m[15][1] = 1'b1;
      if (hb) m[15][0] = 1'b1;
    end
  end

  task automatic check8(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  // compare on every clock, a quarter period after the falling edge
  always @(negedge clk) begin
    if (live) begin
      #5;
      check8(tag, "rd_data", rd_data, m[addr]);
      check8("R4", "adj_pulse", {7'd0, adj_pulse}, {7'd0, madj});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles expected < 100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int a, input bit we, input int d, input bit stp, input bit osc);
    @(negedge clk);
    addr        = 4'(a);
    wr_en       = we;
    wr_data     = 8'(d);
    stop_strobe = stp;
    osc_stop    = osc;
  endtask

  task automatic wr(input int a, input int d);
    step(a, 1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic rd(input int a);
    step(a, 1'b0, 0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; wr_data = '0;
    stop_strobe = 1'b0; osc_stop = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R3: reset contents
    tag = "R3";
    for (int a = 0; a < 16; a++) rd(a);

    // R1: all-ones writes, unused bits read 0
    tag = "R1";
    for (int a = 0; a < 16; a++) begin wr(a, 8'hFF); rd(a); end
    for (int a = 0; a < 15; a++) wr(a, 8'h00);
    wr(15, 8'h00);
    rd(15);

    // R2: distinct patterns per index
    tag = "R2";
    for (int a = 0; a < 14; a++) begin wr(a, (a * 8'h13 + 8'h25) & 8'hFF); rd(a); end

    // R10: combinational read, new index each cycle
    tag = "R10";
    for (int a = 13; a >= 0; a--) rd(a);

    // R7: stop strobe clears the test bit, and beats a simultaneous write
    tag = "R7";
    wr(14, 8'h08); rd(14);
    step(14, 1'b0, 0, 1'b1, 1'b0); rd(14);
    step(14, 1'b1, 8'h0F, 1'b1, 1'b0); rd(14);
    wr(14, 8'h00);

    // R4: adjust request pulse, stop flag untouched
    tag = "R4";
    wr(15, 8'h10); rd(15); rd(15);
    wr(15, 8'h10); wr(15, 8'h10); rd(15); rd(15);

    // R6: oscillator stop resets selected fields, beats a write
    tag = "R6";
    wr(7, 8'h55); wr(14, 8'hCF); wr(15, 8'h08); rd(15);
    step(15, 1'b0, 0, 1'b0, 1'b1); rd(7); rd(14); rd(15);
    wr(15, 8'h08);
    step(15, 1'b1, 8'h08, 1'b0, 1'b1); rd(15);

    // R5: writing 0 clears the stop flag
    tag = "R5";
    wr(15, 8'h00); rd(15);
    wr(15, 8'h20); rd(15);
    wr(15, 8'h00);

    // R8: alarm matching
    tag = "R8";
    wr(1, 8'h30); wr(2, 8'h12); wr(3, 8'h03);
    wr(8, 8'h30); wr(9, 8'h12); wr(10, 8'h08);
    wr(11, 8'h30); wr(12, 8'h12); wr(13, 8'h77);
    rd(15);
    wr(14, 8'h80); rd(15); rd(15);
    wr(14, 8'hC0); rd(15); rd(15);
    wr(3, 8'h07); rd(15);
    wr(15, 8'h00); rd(15);
    wr(14, 8'h00); wr(3, 8'h03); rd(15); rd(15);
    wr(10, 8'h00); wr(14, 8'h80); rd(15);

    // R9: flag persistence and clearing
    tag = "R9";
    wr(10, 8'h08); rd(15); rd(15);
    wr(3, 8'h05); rd(15);
    wr(15, 8'h02); rd(15);
    wr(15, 8'h00); rd(15);
    wr(3, 8'h03); rd(15);
    wr(15, 8'h00); rd(15);
    wr(14, 8'h00); wr(15, 8'h00); rd(15); rd(15);

    live = 1'b0;
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule